// File: doc/BRIEF.md
# Configuration Readback Engine

A host-bus slave that lets a processor read a device's configuration memory through a small block of byte-wide registers while the device runs its user logic. The host loads a 14-bit start address into two address registers, sets the enable bit, and starts a transfer by writing the run bit of the control register to 0. The engine then fetches bytes one at a time from a fixed-latency configuration memory port. Each byte goes into the data register and raises the ready flag in the status register.

A host read of the data register while ready is set consumes the byte. The engine advances the address, wrapping from 0x3FFF to 0, and fetches the next byte. Writing the run bit back to 1 lets the byte already in progress arrive, then stops. The engine does no integrity checking on the data. While a transfer is active, it holds the serial-readback valid strobe low.

Top module: `cfg_readback_engine`

## Requirements
- R1: After reset, the control register reads 0x02 (enable bit 0 = 0, run bit 1 = 1). Status, both address registers and the data register read 0. `mem_req_o` is 0.
- R2: Register map on `bus_addr_i`: 0 control, 1 status (bit 0 = ready), 2 start address bits 13:8 (held in data bits 5:0, upper bits read 0), 3 start address bits 7:0, 4 data byte (read only). Written values read back.
- R3: While the enable bit is 0, writes to the address registers and to the run bit are ignored, and ready stays 0. A control write may still set the enable bit, but it starts no fetch in that same write.
- R4: A control write with bit 0 = 1 and bit 1 = 0, made while enable is already 1, starts readback. In the next cycle, `mem_req_o` is 1 for one cycle with `mem_addr_o` equal to the start address. Ready rises MEM_LAT+1 cycles after that request cycle.
- R5: While ready is 1, the data register holds the byte the memory returned for the current address. It keeps that byte until the next byte is captured.
- R6: A host read of the data register while ready is 1 clears ready at that edge. In the next cycle, the engine issues a fetch of the previous address plus one.
- R7: The fetch address wraps from 0x3FFF to 0x0000.
- R8: A new start reloads the address from the address registers, clears ready, and discards any fetch still in flight.
- R9: After the run bit is written to 1, the fetch in progress still delivers its byte. Once that byte is consumed, no further fetch is issued.
- R10: A control write that clears the enable bit aborts readback at once: ready goes to 0, the run bit reads 1, and no fetch is issued afterwards.
- R11: `ser_valid_o` follows `ser_valid_i` when the engine is idle and is 0 while a readback is active.
- R12: No fetch is issued while a byte is waiting to be consumed, and at most one fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register index |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from `bus_addr_i` |
| mem_req_o | output | 1 | Fetch request, one cycle |
| mem_addr_o | output | 14 | Fetch address |
| mem_rdata_i | input | 8 | Memory byte, valid MEM_LAT cycles after the request edge |
| ser_valid_i | input | 1 | Serial-readback valid strobe from the serial path |
| ser_valid_o | output | 1 | Gated serial valid strobe |

## Verification
The assertions assume that the memory returns the byte for the sampled address exactly MEM_LAT edges after the request. They also assume that the host makes at most one register access per cycle and does not change the address registers in the same cycle as a start. The bench memory model is a MEM_LAT-deep register chain fed from `mem_addr_o`, so the latency assumption holds by construction. Host tasks drive a single access and then leave one idle cycle, so accesses never overlap. Runs are set up so that restarts land both on a held byte and on a fetch still in the latency window.

// File: rtl/cfgrb_pkg.sv
package cfgrb_pkg;
  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_RUNN = 1;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_STAT    = 3'd1,
    REG_ADDR_HI = 3'd2,
    REG_ADDR_LO = 3'd3,
    REG_DATA    = 3'd4
  } reg_idx_e;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_ISSUE,
    FS_WAIT,
    FS_HOLD
  } fetch_st_e;
endpackage

// File: rtl/cfgrb_lat_pipe.sv
// Tracks the in-flight fetch across the fixed memory latency.
module cfgrb_lat_pipe #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic in_i,
  output logic out_o
);
  logic [DEPTH-1:0] tag_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      tag_q <= '0;
        else if (flush_i) tag_q <= '0;
        else              tag_q <= in_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      tag_q <= '0;
        else if (flush_i) tag_q <= '0;
        else              tag_q <= {tag_q[DEPTH-2:0], in_i};
      end
    end
  endgenerate

  assign out_o = tag_q[DEPTH-1];
endmodule

// File: rtl/cfgrb_regs.sv
module cfgrb_regs
  import cfgrb_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [REG_IDX_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  input  logic                 data_rdy_i,
  input  logic [DATA_W-1:0]    data_i,
  output logic                 en_o,
  output logic                 runn_o,
  output logic                 start_o,
  output logic                 abort_o,
  output logic                 consume_o,
  output logic [ADDR_W-1:0]    start_addr_o
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic            en_q, runn_q;
  logic [HI_W-1:0] hi_q;
  logic [DATA_W-1:0] lo_q;
  logic wr, rd, wr_ctrl;

  assign wr      = bus_sel_i & bus_we_i;
  assign rd      = bus_sel_i & ~bus_we_i;
  assign wr_ctrl = wr & (bus_addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      runn_q <= 1'b1;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (wr) begin
      if (bus_addr_i == REG_CTRL) begin
        en_q <= bus_wdata_i[CTRL_EN];
        // run bit only writable while already enabled; disabling parks it at 1
        if (!bus_wdata_i[CTRL_EN])  runn_q <= 1'b1;
        else if (en_q)              runn_q <= bus_wdata_i[CTRL_RUNN];
      end else if (en_q && bus_addr_i == REG_ADDR_HI) begin
        hi_q <= bus_wdata_i[HI_W-1:0];
      end else if (en_q && bus_addr_i == REG_ADDR_LO) begin
        lo_q <= bus_wdata_i;
      end
    end
  end

  assign start_o      = wr_ctrl & en_q & bus_wdata_i[CTRL_EN] & ~bus_wdata_i[CTRL_RUNN];
  assign abort_o      = wr_ctrl & ~bus_wdata_i[CTRL_EN];
  assign consume_o    = rd & (bus_addr_i == REG_DATA) & data_rdy_i;
  assign start_addr_o = {hi_q, lo_q};
  assign en_o         = en_q;
  assign runn_o       = runn_q;

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      REG_CTRL: begin
        bus_rdata_o[CTRL_EN]   = en_q;
        bus_rdata_o[CTRL_RUNN] = runn_q;
      end
      REG_STAT:    bus_rdata_o[0]         = data_rdy_i;
      REG_ADDR_HI: bus_rdata_o[HI_W-1:0]  = hi_q;
      REG_ADDR_LO: bus_rdata_o            = lo_q;
      REG_DATA:    bus_rdata_o            = data_i;
      default:     bus_rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/cfgrb_fetch.sv
module cfgrb_fetch
  import cfgrb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MEM_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              abort_i,
  input  logic              runn_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              consume_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              data_rdy_o,
  output logic [DATA_W-1:0] data_o,
  output logic              busy_o
);
  fetch_st_e         st_q;
  logic [ADDR_W-1:0] cur_q;
  logic [DATA_W-1:0] data_q;
  logic              rdy_q, flush, arrive;

  assign flush = start_i | abort_i | ~en_i;

  cfgrb_lat_pipe #(.DEPTH(MEM_LAT)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(flush),
    .in_i   (mem_req_o),
    .out_o  (arrive)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FS_IDLE;
      cur_q  <= '0;
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else if (abort_i || !en_i) begin
      st_q  <= FS_IDLE;
      rdy_q <= 1'b0;
    end else if (start_i) begin
      st_q  <= FS_ISSUE;
      cur_q <= start_addr_i;
      rdy_q <= 1'b0;
    end else begin
      case (st_q)
        FS_ISSUE: st_q <= FS_WAIT;
        FS_WAIT: if (arrive) begin
          data_q <= mem_rdata_i;
          rdy_q  <= 1'b1;
          st_q   <= FS_HOLD;
        end
        FS_HOLD: if (consume_i) begin
          rdy_q <= 1'b0;
          if (runn_i) st_q <= FS_IDLE;
          else begin
            cur_q <= cur_q + 1'b1;
            st_q  <= FS_ISSUE;
          end
        end
        default: st_q <= FS_IDLE;
      endcase
    end
  end

  assign mem_req_o  = (st_q == FS_ISSUE);
  assign mem_addr_o = cur_q;
  assign data_rdy_o = rdy_q;
  assign data_o     = data_q;
  assign busy_o     = (st_q != FS_IDLE);
endmodule

// File: rtl/cfg_readback_engine.sv
module cfg_readback_engine
  import cfgrb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 14,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MEM_LAT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [REG_IDX_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic                 mem_req_o,
  output logic [ADDR_W-1:0]    mem_addr_o,
  input  logic [DATA_W-1:0]    mem_rdata_i,
  input  logic                 ser_valid_i,
  output logic                 ser_valid_o
);
  logic              en_q, runn_q, start, abort, consume, data_rdy, busy;
  logic [ADDR_W-1:0] start_addr;
  logic [DATA_W-1:0] data_q;

  cfgrb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .data_rdy_i  (data_rdy),
    .data_i      (data_q),
    .en_o        (en_q),
    .runn_o      (runn_q),
    .start_o     (start),
    .abort_o     (abort),
    .consume_o   (consume),
    .start_addr_o(start_addr)
  );

  cfgrb_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_q),
    .abort_i     (abort),
    .runn_i      (runn_q),
    .start_i     (start),
    .start_addr_i(start_addr),
    .consume_i   (consume),
    .mem_rdata_i (mem_rdata_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .data_rdy_o  (data_rdy),
    .data_o      (data_q),
    .busy_o      (busy)
  );

  assign ser_valid_o = ser_valid_i & ~busy;
endmodule

// File: rtl/cfgrb_checker.sv
module cfgrb_checker #(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_q,
  input logic              runn_q,
  input logic              start,
  input logic              consume,
  input logic              data_rdy,
  input logic              busy,
  input logic [ADDR_W-1:0] start_addr,
  input logic [DATA_W-1:0] data_q,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              ser_valid_o
);
  // R3 / R10
  a_r3_ready_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !data_rdy);

  // R4
  a_r4_start_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> mem_req_o && mem_addr_o == $past(start_addr));

  // R5
  a_r5_byte_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy && $past(data_rdy) |-> data_q == $past(data_q));

  // R6 / R7
  a_r6_next_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume && !runn_q && !start |=> !data_rdy && mem_req_o &&
      mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  // R9
  a_r9_stop_after_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume && runn_q |=> !busy && !mem_req_o);

  // R11
  a_r11_serial_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !ser_valid_o);

  // R12
  a_r12_no_req_when_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !data_rdy);
endmodule

bind cfg_readback_engine cfgrb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_q       (en_q),
  .runn_q     (runn_q),
  .start      (start),
  .consume    (consume),
  .data_rdy   (data_rdy),
  .busy       (busy),
  .start_addr (start_addr),
  .data_q     (data_q),
  .mem_req_o  (mem_req_o),
  .mem_addr_o (mem_addr_o),
  .ser_valid_o(ser_valid_o)
);

// File: tb/sim_cfg_readback_engine.sv
`timescale 1ns/1ps
module sim_cfg_readback_engine;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, we;
  logic [2:0]  addr;
  logic [7:0]  wdata, rdata;
  logic        mem_req;
  logic [13:0] mem_addr;
  logic [7:0]  mem_rdata;
  logic        ser_vi, ser_vo;

  int n_chk = 0;
  int n_err = 0;
  int n_req = 0;

  always #2 clk = ~clk;

  cfg_readback_engine #(.ADDR_W(14), .DATA_W(8), .MEM_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .ser_valid_i(ser_vi), .ser_valid_o(ser_vo)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01};
  endfunction

  logic [7:0] mpipe [LAT];
  always @(posedge clk) begin
    mpipe[0] <= pat(mem_addr);
    for (int k = 1; k < LAT; k++) mpipe[k] <= mpipe[k-1];
  end
  assign mem_rdata = mpipe[LAT-1];

  always @(posedge clk) if (rst_n && mem_req) n_req++;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic wait_rdy(output bit ok);
    logic [7:0] s;
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      rd(3'd1, s);
      if (s[0]) begin ok = 1'b1; return; end
    end
  endtask

  task automatic set_addr(input logic [13:0] a);
    wr(3'd2, {2'b00, a[13:8]});
    wr(3'd3, a[7:0]);
  endtask

  task automatic park;
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h03);
  endtask

  task automatic stream(input logic [13:0] a, input int n, input string tag);
    logic [13:0] e;
    logic [7:0]  d;
    bit          ok;
    set_addr(a);
    wr(3'd0, 8'h01);
    for (int j = 0; j < n; j++) begin
      e = a + 14'(j);
      wait_rdy(ok);
      check({tag, " ready"}, int'(ok), 1);
      check("R12 no req while held", int'(mem_req), 0);
      rd(3'd4, d);
      check({tag, " byte"}, int'(d), int'(pat(e)));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    bit          ok;
    int          r0;
    logic [13:0] a;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0; ser_vi = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    check("R1 mem_req", int'(mem_req), 0);
    rd(3'd0, d); check("R1 ctrl", int'(d), 8'h02);
    rd(3'd1, d); check("R1 status", int'(d), 0);
    rd(3'd2, d); check("R1 addr hi", int'(d), 0);
    rd(3'd3, d); check("R1 addr lo", int'(d), 0);
    rd(3'd4, d); check("R1 data", int'(d), 0);
    check("R11 idle passthrough", int'(ser_vo), 1);

    // R3: locked while disabled
    wr(3'd2, 8'h3F); wr(3'd3, 8'hAA);
    rd(3'd2, d); check("R3 hi ignored", int'(d), 0);
    rd(3'd3, d); check("R3 lo ignored", int'(d), 0);
    wr(3'd0, 8'h00);
    rd(3'd0, d); check("R3 run bit ignored", int'(d), 8'h02);
    wr(3'd0, 8'h01);
    rd(3'd0, d); check("R3 enable only", int'(d), 8'h03);
    rd(3'd1, d); check("R3 no ready", int'(d), 0);
    check("R3 no fetch", n_req, 0);

    // R2
    wr(3'd2, 8'hFF); rd(3'd2, d); check("R2 hi width", int'(d), 8'h3F);
    wr(3'd3, 8'h5A); rd(3'd3, d); check("R2 lo", int'(d), 8'h5A);

    // R4 latency, R5, R6
    set_addr(14'h1234);
    wr(3'd0, 8'h01);
    check("R4 req", int'(mem_req), 1);
    check("R4 addr", int'(mem_addr), 14'h1234);
    check("R11 quiet while busy", int'(ser_vo), 0);
    repeat (LAT - 1) @(negedge clk);
    rd(3'd1, d); check("R4 not yet ready", int'(d), 0);
    check("R12 single req", int'(mem_req), 0);
    rd(3'd1, d); check("R4 ready", int'(d), 1);
    rd(3'd4, d); check("R5 byte", int'(d), int'(pat(14'h1234)));
    check("R6 next req", int'(mem_req), 1);
    check("R6 next addr", int'(mem_addr), 14'h1235);
    rd(3'd1, d); check("R6 ready cleared", int'(d), 0);
    rd(3'd4, d); check("R5 byte kept", int'(d), int'(pat(14'h1234)));
    wait_rdy(ok); check("R6 ready again", int'(ok), 1);
    rd(3'd4, d); check("R6 byte", int'(d), int'(pat(14'h1235)));
    park;

    // R7: stream across wrap
    stream(14'h3F00, 512, "R7 wrap");
    park;

    // R4/R8: start sweep, each restart lands on a held or pending byte
    for (int i = 0; i < 64; i++) begin
      a = 14'((i * 263 + i * i * 49) & 16'h3FFF);
      stream(a, 4, "R4 sweep");
    end
    park;

    // R8a: restart over a held byte
    set_addr(14'h0100); wr(3'd0, 8'h01);
    wait_rdy(ok);
    set_addr(14'h2222); wr(3'd0, 8'h01);
    rd(3'd1, d); check("R8 ready cleared", int'(d), 0);
    wait_rdy(ok); check("R8 ready", int'(ok), 1);
    rd(3'd4, d); check("R8 reload byte", int'(d), int'(pat(14'h2222)));
    park;

    // R8b: restart while the first fetch is in flight
    set_addr(14'h0500); wr(3'd0, 8'h01);
    wr(3'd3, 8'h77);
    wr(3'd0, 8'h01);
    wait_rdy(ok);
    rd(3'd4, d); check("R8 in-flight dropped", int'(d), int'(pat(14'h0577)));
    wait_rdy(ok);
    rd(3'd4, d); check("R8 continues", int'(d), int'(pat(14'h0578)));
    park;

    // R9: stop with byte held
    set_addr(14'h0A00); wr(3'd0, 8'h01);
    wait_rdy(ok);
    wr(3'd0, 8'h03);
    rd(3'd4, d); check("R9 held byte", int'(d), int'(pat(14'h0A00)));
    r0 = n_req;
    repeat (12) @(negedge clk);
    check("R9 no more fetch", n_req - r0, 0);
    rd(3'd1, d); check("R9 idle status", int'(d), 0);
    check("R11 passthrough after stop", int'(ser_vo), 1);

    // R9: stop while fetch in flight
    set_addr(14'h0B10); wr(3'd0, 8'h01);
    wr(3'd0, 8'h03);
    wait_rdy(ok); check("R9 in-flight delivered", int'(ok), 1);
    rd(3'd4, d); check("R9 in-flight byte", int'(d), int'(pat(14'h0B10)));
    r0 = n_req;
    repeat (12) @(negedge clk);
    check("R9 stopped", n_req - r0, 0);

    // R10: abort by disable
    set_addr(14'h0C00); wr(3'd0, 8'h01);
    wait_rdy(ok);
    wr(3'd0, 8'h00);
    rd(3'd1, d); check("R10 ready dropped", int'(d), 0);
    rd(3'd0, d); check("R10 ctrl", int'(d), 8'h02);
    r0 = n_req;
    repeat (12) @(negedge clk);
    check("R10 no fetch", n_req - r0, 0);
    check("R11 passthrough after abort", int'(ser_vo), 1);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule